// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Sequencer for an Accumulator Machine

This block is the control unit of a small single-accumulator processor, packaged together with the register datapath, an adder-based ALU and a word-wide memory, so its behaviour can be observed at the pins. Every clock cycle the sequencer occupies one timed step of one sub-cycle. Each sub-cycle has three steps: S_F0..S_F2 for fetch, S_I0..S_I2 for indirect, S_E0..S_E2 for execute and S_Q0..S_Q2 for interrupt. In each step it raises the gate enables for the register transfers of that step, selects the ALU function and drives the memory read and write strobes.

Transitions: S_F0→S_F1→S_F2. From S_F2 it goes to S_I0 when the incoming instruction has its indirect bit set, and to S_E0 otherwise. The indirect path runs S_I0→S_I1→S_I2→S_E0. Execute ends after S_E0 for a jump or an unused opcode, and after S_E2 for load, store and add. When execute ends, the sequencer enters S_Q0 if an interrupt is pending and enabled, and S_F0 if not. The interrupt path runs S_Q0→S_Q1→S_Q2→S_F0. A preload port fills the memory while reset is held.

Top module: `ucyc_core`

## Requirements
- R1: A synchronous active-high reset clears pc and ac, enables interrupts and places the sequencer in fetch step 0 (phase=0, step=0).
- R2: phase encodes the sub-cycle (0 fetch, 1 indirect, 2 execute, 3 interrupt) and step encodes 0..2. Each clock advances exactly one step. LOAD, ADD and STORE take 6 cycles, JUMP and unused opcodes take 4, and an indirect reference adds 3.
- R3: In fetch step 0 the MAR is loaded from pc, so bus_addr equals pc during fetch step 1.
- R4: In fetch step 1 mem_rd is high, the MBR captures the addressed word, and pc increments by one in the same step.
- R5: In fetch step 2 the IR is loaded from the MBR. The next step is indirect step 0 if IR bit 15 is 1, and execute step 0 otherwise.
- R6: The indirect sub-cycle loads the MAR from the IR address field, reads memory into the MBR, and replaces the IR address field with the low address bits of the MBR. It then enters execute step 0.
- R7: Instruction bits 14:12 give the opcode and the low AW bits give the address. Opcode 0 loads ac from memory, 1 stores ac to memory, 2 adds the memory word to ac, and 3 jumps (pc takes the address). Opcodes 4 to 7 do nothing.
- R8: When execute ends with irq high and interrupts enabled, the interrupt sub-cycle writes pc to SAVE_ADDR, sets pc to VEC_ADDR and disables interrupts. While interrupts are disabled, irq has no effect.
- R9: In any step at most one source loads each of MAR, MBR, PC and IR, and mem_rd and mem_wr are never high together.
- R10: A word written to memory by STORE is returned by later reads of the same address. The preload port writes the memory whenever ld_we is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Interrupt request |
| ld_we | input | 1 | Preload write enable |
| ld_addr | input | AW | Preload address |
| ld_data | input | DW | Preload data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| bus_addr | output | AW | System address bus (MAR) |
| phase | output | 2 | Active sub-cycle |
| step | output | 2 | Active step within the sub-cycle |
| pc | output | AW | Program counter |
| ac | output | DW | Accumulator |
| ir | output | DW | Instruction register |

## Verification
The bench builds the block with its defaults: DW=16 and AW=8, which gives a 256-word memory, SAVE_ADDR=0xF0 and VEC_ADDR=0x40. With these values one short program can reach every opcode, both direct and indirect references, a store that is read back, an unused opcode, an interrupt taken at the end of a jump, and a later request that is ignored. The saved return address is observed by loading it from SAVE_ADDR at the vector.

// File: rtl/ucyc_pkg.sv
package ucyc_pkg;

    typedef enum logic [3:0] {
        S_F0, S_F1, S_F2,
        S_I0, S_I1, S_I2,
        S_E0, S_E1, S_E2,
        S_Q0, S_Q1, S_Q2
    } ucyc_state_e;

    typedef enum logic {
        ALU_PASS = 1'b0,
        ALU_ADD  = 1'b1
    } ucyc_alu_e;

    typedef struct packed {
        logic      pc_to_mar;
        logic      ir_to_mar;
        logic      sav_to_mar;
        logic      mem_to_mbr;
        logic      ac_to_mbr;
        logic      pc_to_mbr;
        logic      pc_inc;
        logic      ir_to_pc;
        logic      vec_to_pc;
        logic      mbr_to_ir;
        logic      mbr_to_iradr;
        logic      alu_to_ac;
        logic      ien_clr;
        logic      mem_rd;
        logic      mem_wr;
        ucyc_alu_e alu_fn;
    } ucyc_ctl_t;

    localparam logic [2:0] OP_LOAD  = 3'd0;
    localparam logic [2:0] OP_STORE = 3'd1;
    localparam logic [2:0] OP_ADD   = 3'd2;
    localparam logic [2:0] OP_JUMP  = 3'd3;

    localparam logic [1:0] PH_FETCH = 2'd0;
    localparam logic [1:0] PH_IND   = 2'd1;
    localparam logic [1:0] PH_EXEC  = 2'd2;
    localparam logic [1:0] PH_INT   = 2'd3;

endpackage

// File: rtl/ucyc_ctrl.sv
module ucyc_ctrl
    import ucyc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  op,
    input  logic        ind_next,
    input  logic        irq,
    input  logic        ien,
    output ucyc_ctl_t   ctl,
    output ucyc_state_e st,
    output logic [1:0]  phase,
    output logic [1:0]  step
);

    ucyc_state_e st_q, st_d;
    ucyc_state_e exec_done;
    logic        short_op;

    assign st       = st_q;
    assign short_op = (op == OP_JUMP) || (op > OP_JUMP);
    assign exec_done = (irq && ien) ? S_Q0 : S_F0;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= S_F0;
        else     st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_F0: st_d = S_F1;
            S_F1: st_d = S_F2;
            S_F2: st_d = ind_next ? S_I0 : S_E0;
            S_I0: st_d = S_I1;
            S_I1: st_d = S_I2;
            S_I2: st_d = S_E0;
            S_E0: st_d = short_op ? exec_done : S_E1;
            S_E1: st_d = S_E2;
            S_E2: st_d = exec_done;
            S_Q0: st_d = S_Q1;
            S_Q1: st_d = S_Q2;
            S_Q2: st_d = S_F0;
            default: st_d = S_F0;
        endcase
    end

    // outputs per step
    always_comb begin
        ctl   = '0;
        phase = PH_FETCH;
        step  = 2'd0;
        unique case (st_q)
            S_F0: begin
                ctl.pc_to_mar = 1'b1;
            end
            S_F1: begin
                step           = 2'd1;
                ctl.mem_rd     = 1'b1;
                ctl.mem_to_mbr = 1'b1;
                ctl.pc_inc     = 1'b1;
            end
            S_F2: begin
                step          = 2'd2;
                ctl.mbr_to_ir = 1'b1;
            end
            S_I0: begin
                phase         = PH_IND;
                ctl.ir_to_mar = 1'b1;
            end
            S_I1: begin
                phase          = PH_IND;
                step           = 2'd1;
                ctl.mem_rd     = 1'b1;
                ctl.mem_to_mbr = 1'b1;
            end
            S_I2: begin
                phase            = PH_IND;
                step             = 2'd2;
                ctl.mbr_to_iradr = 1'b1;
            end
            S_E0: begin
                phase = PH_EXEC;
                if (op == OP_JUMP)  ctl.ir_to_pc  = 1'b1;
                else if (!short_op) ctl.ir_to_mar = 1'b1;
            end
            S_E1: begin
                phase = PH_EXEC;
                step  = 2'd1;
                if (op == OP_STORE) begin
                    ctl.ac_to_mbr = 1'b1;
                end else begin
                    ctl.mem_rd     = 1'b1;
                    ctl.mem_to_mbr = 1'b1;
                end
            end
            S_E2: begin
                phase = PH_EXEC;
                step  = 2'd2;
                if (op == OP_STORE) begin
                    ctl.mem_wr = 1'b1;
                end else begin
                    ctl.alu_to_ac = 1'b1;
                    ctl.alu_fn    = (op == OP_ADD) ? ALU_ADD : ALU_PASS;
                end
            end
            S_Q0: begin
                phase          = PH_INT;
                ctl.sav_to_mar = 1'b1;
                ctl.pc_to_mbr  = 1'b1;
            end
            S_Q1: begin
                phase      = PH_INT;
                step       = 2'd1;
                ctl.mem_wr = 1'b1;
            end
            S_Q2: begin
                phase         = PH_INT;
                step          = 2'd2;
                ctl.vec_to_pc = 1'b1;
                ctl.ien_clr   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ucyc_alu.sv
module ucyc_alu
    import ucyc_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  ucyc_alu_e     fn,
    output logic [DW-1:0] y
);

    always_comb begin
        unique case (fn)
            ALU_ADD:  y = a + b;
            default:  y = b;
        endcase
    end

endmodule

// File: rtl/ucyc_mem.sv
module ucyc_mem #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    output logic [DW-1:0] rdata
);

    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (ld_we)   mem[ld_addr] <= ld_data;
        else if (we) mem[addr]    <= wdata;
    end

endmodule

// File: rtl/ucyc_dpath.sv
module ucyc_dpath
    import ucyc_pkg::*;
#(
    parameter int            DW        = 16,
    parameter int            AW        = 8,
    parameter logic [AW-1:0] SAVE_ADDR = 'hF0,
    parameter logic [AW-1:0] VEC_ADDR  = 'h40
) (
    input  logic          clk,
    input  logic          rst,
    input  ucyc_ctl_t     ctl,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] mar,
    output logic [DW-1:0] mbr,
    output logic [DW-1:0] ir,
    output logic [DW-1:0] ac,
    output logic          ien
);

    localparam logic [AW-1:0] ONE = AW'(1);

    logic [DW-1:0] alu_y;

    ucyc_alu #(.DW(DW)) u_alu (
        .a  (ac),
        .b  (mbr),
        .fn (ctl.alu_fn),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            mar <= '0;
            mbr <= '0;
            ir  <= '0;
            ac  <= '0;
            ien <= 1'b1;
        end else begin
            if (ctl.pc_to_mar)       mar <= pc;
            else if (ctl.ir_to_mar)  mar <= ir[AW-1:0];
            else if (ctl.sav_to_mar) mar <= SAVE_ADDR;

            if (ctl.mem_to_mbr)      mbr <= mem_rdata;
            else if (ctl.ac_to_mbr)  mbr <= ac;
            else if (ctl.pc_to_mbr)  mbr <= {{(DW-AW){1'b0}}, pc};

            if (ctl.pc_inc)          pc <= pc + ONE;
            else if (ctl.ir_to_pc)   pc <= ir[AW-1:0];
            else if (ctl.vec_to_pc)  pc <= VEC_ADDR;

            if (ctl.mbr_to_ir)         ir <= mbr;
            else if (ctl.mbr_to_iradr) ir[AW-1:0] <= mbr[AW-1:0];

            if (ctl.alu_to_ac) ac <= alu_y;
            if (ctl.ien_clr)   ien <= 1'b0;
        end
    end

endmodule

// File: rtl/ucyc_core.sv
module ucyc_core
    import ucyc_pkg::*;
#(
    parameter int            DW        = 16,
    parameter int            AW        = 8,
    parameter logic [AW-1:0] SAVE_ADDR = 'hF0,
    parameter logic [AW-1:0] VEC_ADDR  = 'h40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          irq,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    phase,
    output logic [1:0]    step,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] ac,
    output logic [DW-1:0] ir
);

    localparam int IND_BIT = DW - 1;
    localparam int OP_HI   = DW - 2;
    localparam int OP_LO   = DW - 4;

    ucyc_ctl_t     ctl;
    ucyc_state_e   st;
    logic [AW-1:0] mar_q;
    logic [DW-1:0] mbr_q;
    logic [DW-1:0] rdata;
    logic          ien_q;

    ucyc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .op       (ir[OP_HI:OP_LO]),
        .ind_next (mbr_q[IND_BIT]),
        .irq      (irq),
        .ien      (ien_q),
        .ctl      (ctl),
        .st       (st),
        .phase    (phase),
        .step     (step)
    );

    ucyc_dpath #(
        .DW(DW), .AW(AW), .SAVE_ADDR(SAVE_ADDR), .VEC_ADDR(VEC_ADDR)
    ) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (rdata),
        .pc        (pc),
        .mar       (mar_q),
        .mbr       (mbr_q),
        .ir        (ir),
        .ac        (ac),
        .ien       (ien_q)
    );

    ucyc_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk     (clk),
        .addr    (mar_q),
        .we      (ctl.mem_wr),
        .wdata   (mbr_q),
        .ld_we   (ld_we),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .rdata   (rdata)
    );

    assign mem_rd   = ctl.mem_rd;
    assign mem_wr   = ctl.mem_wr;
    assign bus_addr = mar_q;

endmodule

// File: rtl/ucyc_chk.sv
module ucyc_chk
    import ucyc_pkg::*;
#(
    parameter int            AW       = 8,
    parameter logic [AW-1:0] VEC_ADDR = 'h40
) (
    input  logic          clk,
    input  logic          rst,
    input  ucyc_state_e   st,
    input  ucyc_ctl_t     ctl,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] mar,
    input  logic          mbr_ind,
    input  logic          ien
);

    // R9
    mar_src_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.pc_to_mar, ctl.ir_to_mar, ctl.sav_to_mar}));
    // R9
    mbr_src_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.mem_to_mbr, ctl.ac_to_mbr, ctl.pc_to_mbr}));
    // R9
    pc_src_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.pc_inc, ctl.ir_to_pc, ctl.vec_to_pc}));
    // R9
    ir_src_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.mbr_to_ir, ctl.mbr_to_iradr}));
    // R9
    rdwr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctl.mem_rd && ctl.mem_wr));
    // R3
    fetch_mar_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_F0) |=> (mar == $past(pc)));
    // R4
    fetch_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_F1) |=> (pc == $past(pc) + AW'(1)));
    // R5
    fetch_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_F2) |=> (st == ($past(mbr_ind) ? S_I0 : S_E0)));
    // R6
    ind_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_I2) |=> (st == S_E0));
    // R8
    int_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_Q2) |=> (pc == VEC_ADDR));
    // R8
    ien_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ien) |-> ($past(st) == S_Q2));

endmodule

bind ucyc_core ucyc_chk #(.AW(AW), .VEC_ADDR(VEC_ADDR)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .st      (st),
    .ctl     (ctl),
    .pc      (pc),
    .mar     (mar_q),
    .mbr_ind (mbr_q[DW-1]),
    .ien     (ien_q)
);

// File: tb/ucyc_core_tb.sv
module ucyc_core_tb;

    localparam int DW = 16;
    localparam int AW = 8;

    typedef struct {
        logic [AW-1:0] pc;
        logic [DW-1:0] ac;
        int            gap;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          irq = 1'b0;
    logic          ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic          mem_rd, mem_wr;
    logic [AW-1:0] bus_addr, pc;
    logic [1:0]    phase, step;
    logic [DW-1:0] ac, ir;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int last_cyc = 0;
    int intr_cycles = 0;
    bit done = 1'b0;
    exp_t q[$];

    ucyc_core u_dut (
        .clk(clk), .rst(rst), .irq(irq),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .bus_addr(bus_addr),
        .phase(phase), .step(step), .pc(pc), .ac(ac), .ir(ir)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] ins(input bit ind, input int op, input int a);
        return {ind, 3'(op), 12'(a)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic preload(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = AW'(a); ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic push(input int p, input int a, input int g);
        exp_t e;
        e.pc = AW'(p); e.ac = DW'(a); e.gap = g;
        q.push_back(e);
    endtask

    // monitor / scoreboard
    logic [1:0]    prev_ph = '0, prev_st = '0;
    logic [AW-1:0] prev_pc = '0;
    always @(negedge clk) begin
        if (rst) begin
            prev_ph <= 2'd3; prev_st <= 2'd3;
        end else begin
            // R9
            check(!(mem_rd && mem_wr), "R9 rd/wr", {mem_rd, mem_wr}, 0);
            if (phase == 2'd0 && step == 2'd1) begin
                check(mem_rd, "R4 read strobe", mem_rd, 1);
                check(bus_addr == pc, "R3 mar<=pc", bus_addr, pc);
            end
            if (prev_ph == 2'd0 && prev_st == 2'd1)
                check(pc == prev_pc + AW'(1), "R4 pc+1", pc, prev_pc + AW'(1));
            if (prev_ph == 2'd0 && prev_st == 2'd2)
                check(phase == (ir[15] ? 2'd1 : 2'd2) && step == 2'd0,
                      "R5 branch", {phase, step}, ir[15] ? 4 : 8);
            if (prev_ph == 2'd1 && prev_st == 2'd2)
                check(phase == 2'd2 && step == 2'd0, "R6 exit", {phase, step}, 8);
            if (phase == 2'd3) intr_cycles <= intr_cycles + 1;
            if (phase == 2'd0 && step == 2'd0 && q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                // R7 R10 architectural state at instruction boundary
                check(pc == e.pc, "R7 pc", pc, e.pc);
                check(ac == e.ac, "R7 ac", ac, e.ac);
                // R2 step timing
                if (e.gap != 0) check(cyc - last_cyc == e.gap, "R2 cycles", cyc - last_cyc, e.gap);
                last_cyc <= cyc;
            end
            prev_ph <= phase; prev_st <= step; prev_pc <= pc;
        end
    end

    initial begin
        preload(8'h00, ins(0, 0, 8'h20));
        preload(8'h01, ins(0, 2, 8'h21));
        preload(8'h02, ins(0, 1, 8'h22));
        preload(8'h03, ins(1, 2, 8'h23));
        preload(8'h04, ins(0, 7, 0));
        preload(8'h05, ins(0, 3, 8'h08));
        preload(8'h08, ins(1, 0, 8'h24));
        preload(8'h09, ins(0, 2, 8'h22));
        preload(8'h0A, ins(0, 3, 8'h0A));
        preload(8'h20, 16'd5);
        preload(8'h21, 16'd7);
        preload(8'h22, 16'd0);
        preload(8'h23, 16'h0022);
        preload(8'h24, 16'h0021);
        preload(8'h40, ins(0, 0, 8'hF0));
        preload(8'h41, ins(0, 3, 8'h41));
        @(negedge clk);
        // R1 reset state
        check(phase == 2'd0 && step == 2'd0, "R1 state", {phase, step}, 0);
        check(pc == '0, "R1 pc", pc, 0);
        check(ac == '0, "R1 ac", ac, 0);
        push(0, 0, 0);   push(1, 5, 6);   push(2, 12, 6);  push(3, 12, 6);
        push(4, 24, 9);  push(5, 24, 4);  push(8, 24, 4);  push(9, 7, 9);
        push(10, 19, 6);
        rst = 1'b0;
        while (q.size() != 0) @(negedge clk);
        // R8 interrupt taken at end of the jump at 0x0A, saved pc read back at vector
        irq = 1'b1;
        push(8'h40, 19, 7); push(8'h41, 10, 6);
        while (q.size() != 0) @(negedge clk);
        // R8 further requests ignored once disabled
        push(8'h41, 10, 4); push(8'h41, 10, 4);
        while (q.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
        check(intr_cycles == 3, "R8 interrupt steps", intr_cycles, 3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", q.size(), 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule